// File: doc/BRIEF.md
# Indexed Configuration Register Bank

This block puts a bank of configuration registers behind a two-address host port on an 8-bit I/O bus. The host writes a register number to the index address. It then reads or writes the selected register through the data address. Low register numbers are global to the chip. Register numbers 0x30 and above are banked: a device-select register chooses which device's bank they reach. Only the serial-flash device bank (device number 0x06) is implemented.

From these registers the block drives a pin-function enable, a device activation bit, their AND as the flash master enable, and a 16-bit I/O base address built from a high byte and a low byte. All of these go to the flash master.

A host state machine controls access. It has three states:

- `ST_LOCKED`: extended mode is off.
- `ST_READY`: accesses are accepted.
- `ST_RESPOND`: one cycle in which read data is presented.

The transitions are:

- `LOCKED→READY` when `ext_en` is seen high.
- `READY→LOCKED` when `ext_en` is low.
- `READY→RESPOND` on an accepted read.
- `RESPOND→READY` if `ext_en` is high.
- `RESPOND→LOCKED` if `ext_en` is low.

Top module: `cfg_index_bank`

## Requirements
- R1: After reset every register reads 0x00 except the identifier, and `rd_valid`, `flash_pin_en`, `flash_act`, `flash_en` and `flash_base` are all 0.
- R2: A write with `bus_sel`=0 loads the index register. A read with `bus_sel`=0 returns the index register.
- R3: Register 0x20 always reads 0xA0. Writes to it have no effect.
- R4: Register 0x07 is the device-select register and reads back what was written to it.
- R5: Register 0x24 stores all 8 bits. `flash_pin_en` equals its bit 1.
- R6: While device-select is 0x06, register 0x30 is stored and `flash_act` equals its bit 0. In the same bank, registers 0x62 and 0x63 hold the high and low bytes of `flash_base`.
- R7: `flash_en` is high exactly when both `flash_pin_en` and `flash_act` are high.
- R8: While device-select is not 0x06, indexes 0x30 and above read 0xFF and writes to them have no effect.
- R9: Unimplemented global indexes (below 0x30, other than 0x07, 0x20 and 0x24) read 0xFF, as do unimplemented indexes in bank 0x06.
- R10: An access is accepted only in `ST_READY` with `ext_en` high. `ST_READY` is entered one clock after `ext_en` is first seen high, so the first cycle of `ext_en` is ignored. Accesses with `ext_en` low are ignored.
- R11: After an accepted read sampled at a clock edge, `rd_valid` is high for exactly the following cycle, with the data on `rd_data`. Any access sampled at the edge that ends the `ST_RESPOND` cycle is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_en | input | 1 | Extended-mode enable; gates all accesses |
| bus_wr | input | 1 | Host write strobe |
| bus_rd | input | 1 | Host read strobe |
| bus_sel | input | 1 | 0 = index address, 1 = data address |
| bus_wdata | input | 8 | Host write data |
| rd_valid | output | 1 | Read data valid (one cycle) |
| rd_data | output | 8 | Read data |
| flash_pin_en | output | 1 | Flash pin function enabled (reg 0x24 bit 1) |
| flash_act | output | 1 | Flash device activated (bank 6 reg 0x30 bit 0) |
| flash_en | output | 1 | Flash master enable |
| flash_base | output | 16 | Flash master I/O base address |

## Verification
A wrong index or device-select value does not show at the ports until a data access is made. It then appears in the cycle after the read as an unexpected `rd_data`, or, after a write, as a change to the wrong output. A wrong host state shows up one cycle after the access that should have been accepted or ignored: `rd_valid` goes missing or appears when it should not, or `flash_base` or the enables change when they should not. The bench compares every output against a behavioural model on every clock, so any divergence is reported within one cycle of its first visible effect.

// File: rtl/cfg_bank_pkg.sv
package cfg_bank_pkg;
    localparam int BUS_W = 8;

    typedef enum logic [1:0] {
        ST_LOCKED  = 2'd0,
        ST_READY   = 2'd1,
        ST_RESPOND = 2'd2
    } host_state_t;

    localparam logic [BUS_W-1:0] IDX_DEVSEL  = 8'h07;
    localparam logic [BUS_W-1:0] IDX_CHIPID  = 8'h20;
    localparam logic [BUS_W-1:0] IDX_PINFN   = 8'h24;
    localparam logic [BUS_W-1:0] IDX_BANKLO  = 8'h30;
    localparam logic [BUS_W-1:0] IDX_DEVACT  = 8'h30;
    localparam logic [BUS_W-1:0] IDX_BASE_HI = 8'h62;
    localparam logic [BUS_W-1:0] IDX_BASE_LO = 8'h63;
    localparam logic [BUS_W-1:0] NO_REG      = 8'hFF;
endpackage

// File: rtl/cfg_host_fsm.sv
module cfg_host_fsm
    import cfg_bank_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ext_en,
    input  logic bus_wr,
    input  logic bus_rd,
    output logic wr_ok,
    output logic rd_ok,
    output logic rsp_valid
);
    host_state_t state_q, state_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_LOCKED;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_LOCKED:  state_d = ext_en ? ST_READY : ST_LOCKED;
            ST_READY: begin
                if (!ext_en)     state_d = ST_LOCKED;
                else if (bus_rd) state_d = ST_RESPOND;
                else             state_d = ST_READY;
            end
            ST_RESPOND: state_d = ext_en ? ST_READY : ST_LOCKED;
            default:    state_d = ST_LOCKED;
        endcase
    end

    // outputs
    always_comb begin
        wr_ok     = 1'b0;
        rd_ok     = 1'b0;
        rsp_valid = 1'b0;
        unique case (state_q)
            ST_LOCKED:  ;
            ST_READY: begin
                wr_ok = ext_en & bus_wr;
                rd_ok = ext_en & bus_rd;
            end
            ST_RESPOND: rsp_valid = 1'b1;
            default:    ;
        endcase
    end
endmodule

// File: rtl/cfg_reg_file.sv
module cfg_reg_file
    import cfg_bank_pkg::*;
#(
    parameter int                DW        = BUS_W,
    parameter logic [BUS_W-1:0]  CHIP_ID   = 8'hA0,
    parameter logic [BUS_W-1:0]  FLASH_DEV = 8'h06
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_ok,
    input  logic          rd_ok,
    input  logic          sel_data,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    output logic          pin_en,
    output logic          dev_act,
    output logic [2*DW-1:0] base
);
    localparam int NBYTE = 2;

    logic [DW-1:0] index_q, devsel_q, pinfn_q, act_q;
    logic [DW-1:0] base_q [NBYTE];
    logic [DW-1:0] data_mux;
    logic          bank_hit;

    assign bank_hit = (devsel_q == FLASH_DEV);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            index_q  <= '0;
            devsel_q <= '0;
            pinfn_q  <= '0;
            act_q    <= '0;
        end else if (wr_ok) begin
            if (!sel_data) begin
                index_q <= wdata;
            end else if (index_q < IDX_BANKLO) begin
                if (index_q == IDX_DEVSEL) devsel_q <= wdata;
                if (index_q == IDX_PINFN)  pinfn_q  <= wdata;
            end else if (bank_hit && index_q == IDX_DEVACT) begin
                act_q <= wdata;
            end
        end
    end

    // base address bytes: byte 1 = high (0x62), byte 0 = low (0x63)
    for (genvar b = 0; b < NBYTE; b++) begin : g_base
        localparam logic [DW-1:0] MY_IDX = (b == 1) ? IDX_BASE_HI : IDX_BASE_LO;
        always_ff @(posedge clk) begin
            if (!rst_n)
                base_q[b] <= '0;
            else if (wr_ok && sel_data && bank_hit && index_q == MY_IDX)
                base_q[b] <= wdata;
        end
        assign base[b*DW +: DW] = base_q[b];
    end

    always_comb begin
        data_mux = NO_REG;
        if (index_q < IDX_BANKLO) begin
            case (index_q)
                IDX_DEVSEL: data_mux = devsel_q;
                IDX_CHIPID: data_mux = CHIP_ID;
                IDX_PINFN:  data_mux = pinfn_q;
                default:    data_mux = NO_REG;
            endcase
        end else if (bank_hit) begin
            case (index_q)
                IDX_DEVACT:  data_mux = act_q;
                IDX_BASE_HI: data_mux = base_q[1];
                IDX_BASE_LO: data_mux = base_q[0];
                default:     data_mux = NO_REG;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)     rdata <= '0;
        else if (rd_ok) rdata <= sel_data ? data_mux : index_q;
    end

    assign pin_en  = pinfn_q[1];
    assign dev_act = act_q[0];
endmodule

// File: rtl/cfg_index_bank.sv
module cfg_index_bank
    import cfg_bank_pkg::*;
#(
    parameter int               DW        = BUS_W,
    parameter logic [BUS_W-1:0] CHIP_ID   = 8'hA0,
    parameter logic [BUS_W-1:0] FLASH_DEV = 8'h06
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ext_en,
    input  logic            bus_wr,
    input  logic            bus_rd,
    input  logic            bus_sel,
    input  logic [DW-1:0]   bus_wdata,
    output logic            rd_valid,
    output logic [DW-1:0]   rd_data,
    output logic            flash_pin_en,
    output logic            flash_act,
    output logic            flash_en,
    output logic [2*DW-1:0] flash_base
);
    logic wr_ok, rd_ok;

    cfg_host_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .ext_en    (ext_en),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .wr_ok     (wr_ok),
        .rd_ok     (rd_ok),
        .rsp_valid (rd_valid)
    );

    cfg_reg_file #(.DW(DW), .CHIP_ID(CHIP_ID), .FLASH_DEV(FLASH_DEV)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_ok    (wr_ok),
        .rd_ok    (rd_ok),
        .sel_data (bus_sel),
        .wdata    (bus_wdata),
        .rdata    (rd_data),
        .pin_en   (flash_pin_en),
        .dev_act  (flash_act),
        .base     (flash_base)
    );

    assign flash_en = flash_pin_en & flash_act;
endmodule

// File: rtl/cfg_index_bank_chk.sv
module cfg_index_bank_chk #(
    parameter int DW = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            ext_en,
    input logic            bus_wr,
    input logic            bus_rd,
    input logic            bus_sel,
    input logic            rd_valid,
    input logic            flash_pin_en,
    input logic            flash_act,
    input logic            flash_en,
    input logic [2*DW-1:0] flash_base
);
    // R10
    locked_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ext_en && bus_wr) |=> ($stable(flash_base) && $stable(flash_pin_en) && $stable(flash_act)));

    // R11
    rsp_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);

    // R11
    rsp_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(bus_rd && ext_en));

    // R6
    base_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(flash_base) |-> $past(bus_wr && bus_sel && ext_en));

    // R7
    en_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flash_en) |-> $past(bus_wr && bus_sel && ext_en));
endmodule

bind cfg_index_bank cfg_index_bank_chk #(.DW(DW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .ext_en       (ext_en),
    .bus_wr       (bus_wr),
    .bus_rd       (bus_rd),
    .bus_sel      (bus_sel),
    .rd_valid     (rd_valid),
    .flash_pin_en (flash_pin_en),
    .flash_act    (flash_act),
    .flash_en     (flash_en),
    .flash_base   (flash_base)
);

// File: tb/cfg_index_bank_test.sv
`timescale 1ns/1ps
module cfg_index_bank_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ext_en = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0, bus_sel = 1'b0;
    logic [7:0]  bus_wdata = 8'h00;
    logic        rd_valid, flash_pin_en, flash_act, flash_en;
    logic [7:0]  rd_data;
    logic [15:0] flash_base;

    int checks = 0, fails = 0;
    bit done = 0;

    always #4 clk = ~clk;

    cfg_index_bank uut (
        .clk(clk), .rst_n(rst_n), .ext_en(ext_en), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_sel(bus_sel), .bus_wdata(bus_wdata), .rd_valid(rd_valid), .rd_data(rd_data),
        .flash_pin_en(flash_pin_en), .flash_act(flash_act), .flash_en(flash_en),
        .flash_base(flash_base)
    );

    // behavioural reference model
    int         m_mode;   // 0 off, 1 open, 2 answering
    bit         m_rv;
    logic [7:0] m_rd, m_idx, m_dev, m_pin, m_act, m_hi, m_lo;

    function automatic logic [7:0] m_read(input logic [7:0] i);
        if (i == 8'h20) return 8'hA0;
        if (i == 8'h07) return m_dev;
        if (i == 8'h24) return m_pin;
        if (i >= 8'h30 && m_dev == 8'h06) begin
            if (i == 8'h30) return m_act;
            if (i == 8'h62) return m_hi;
            if (i == 8'h63) return m_lo;
        end
        return 8'hFF;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_mode = 0; m_rv = 0; m_rd = 0; m_idx = 0; m_dev = 0;
            m_pin = 0; m_act = 0; m_hi = 0; m_lo = 0;
        end else begin
            bit acc;
            acc = (m_mode == 1) && ext_en;
            m_rv = acc && bus_rd;
            if (m_rv) m_rd = bus_sel ? m_read(m_idx) : m_idx;
            if (acc && bus_wr) begin
                if (!bus_sel) m_idx = bus_wdata;
                else if (m_idx == 8'h07) m_dev = bus_wdata;
                else if (m_idx == 8'h24) m_pin = bus_wdata;
                else if (m_dev == 8'h06 && m_idx == 8'h30) m_act = bus_wdata;
                else if (m_dev == 8'h06 && m_idx == 8'h62) m_hi = bus_wdata;
                else if (m_dev == 8'h06 && m_idx == 8'h63) m_lo = bus_wdata;
            end
            if (!ext_en) m_mode = 0;
            else if (m_mode == 1 && bus_rd) m_mode = 2;
            else m_mode = 1;
        end
    end

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // compare against the model every cycle
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R11", "model rd_valid", {31'b0, rd_valid}, {31'b0, m_rv});
            if (m_rv) chk("R11", "model rd_data", {24'b0, rd_data}, {24'b0, m_rd});
            chk("R5", "model pin_en", {31'b0, flash_pin_en}, {31'b0, m_pin[1]});
            chk("R6", "model act", {31'b0, flash_act}, {31'b0, m_act[0]});
            chk("R7", "model en", {31'b0, flash_en}, {31'b0, m_pin[1] & m_act[0]});
            chk("R6", "model base", {16'b0, flash_base}, {16'b0, m_hi, m_lo});
        end
    end

    task automatic wr(input logic sel, input logic [7:0] d);
        @(negedge clk); bus_wr = 1; bus_sel = sel; bus_wdata = d;
        @(negedge clk); bus_wr = 0;
    endtask

    task automatic rd(input logic sel, input logic [7:0] exp, input string req);
        @(negedge clk); bus_rd = 1; bus_sel = sel;
        @(negedge clk); bus_rd = 0;
        chk(req, "rd_valid", {31'b0, rd_valid}, 32'd1);
        chk(req, "rd_data", {24'b0, rd_data}, {24'b0, exp});
        @(negedge clk);
    endtask

    task automatic finish_run;
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk("R1", "rd_valid", {31'b0, rd_valid}, 0);
        chk("R1", "flash_en", {31'b0, flash_en}, 0);
        chk("R1", "flash_base", {16'b0, flash_base}, 0);
        chk("R1", "pin_en", {31'b0, flash_pin_en}, 0);

        // R10 writes with ext_en low are ignored
        wr(0, 8'h24); wr(1, 8'hFF);
        ext_en = 1; repeat (2) @(negedge clk);
        chk("R10", "pin_en after locked write", {31'b0, flash_pin_en}, 0);
        rd(1, 8'hFF, "R9");          // index still 0x00: unimplemented
        rd(0, 8'h00, "R2");

        wr(0, 8'h20); rd(0, 8'h20, "R2");
        rd(1, 8'hA0, "R3");
        wr(1, 8'h55); rd(1, 8'hA0, "R3");

        wr(0, 8'h24); wr(1, 8'h02);
        chk("R5", "pin_en", {31'b0, flash_pin_en}, 1);
        rd(1, 8'h02, "R5");
        wr(0, 8'h11); rd(1, 8'hFF, "R9");

        // R8 other device bank
        wr(0, 8'h07); wr(1, 8'h05); rd(1, 8'h05, "R4");
        wr(0, 8'h62); wr(1, 8'h12); rd(1, 8'hFF, "R8");
        chk("R8", "base unchanged", {16'b0, flash_base}, 0);
        wr(0, 8'h30); wr(1, 8'h01);
        chk("R8", "act unchanged", {31'b0, flash_act}, 0);

        // R6 flash bank
        wr(0, 8'h07); wr(1, 8'h06);
        wr(0, 8'h62); wr(1, 8'hAB); wr(0, 8'h63); wr(1, 8'hCD);
        chk("R6", "base", {16'b0, flash_base}, 32'hABCD);
        rd(1, 8'hCD, "R6");
        wr(0, 8'h40); rd(1, 8'hFF, "R9");
        chk("R7", "en before act", {31'b0, flash_en}, 0);
        wr(0, 8'h30); wr(1, 8'h01);
        chk("R6", "act", {31'b0, flash_act}, 1);
        chk("R7", "en both set", {31'b0, flash_en}, 1);
        wr(0, 8'h24); wr(1, 8'h00);
        chk("R7", "en pin cleared", {31'b0, flash_en}, 0);

        // R11 write sampled during answer cycle is ignored
        @(negedge clk); bus_rd = 1; bus_sel = 1;
        @(negedge clk); bus_rd = 0; bus_wr = 1; bus_wdata = 8'hFF;
        chk("R11", "rd_valid", {31'b0, rd_valid}, 1);
        chk("R11", "rd_data", {24'b0, rd_data}, 0);
        @(negedge clk); bus_wr = 0;
        chk("R11", "rd_valid one cycle", {31'b0, rd_valid}, 0);
        rd(1, 8'h00, "R11");

        // R10 first cycle of ext_en is ignored
        ext_en = 0; @(negedge clk);
        ext_en = 1; bus_wr = 1; bus_sel = 1; bus_wdata = 8'h02;
        @(negedge clk); bus_wr = 0;
        @(negedge clk);
        chk("R10", "first-cycle write ignored", {31'b0, flash_pin_en}, 0);
        rd(1, 8'h00, "R10");
        wr(1, 8'h02);
        chk("R10", "write accepted later", {31'b0, flash_pin_en}, 1);
        chk("R7", "en restored", {31'b0, flash_en}, 1);

        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule